// File: doc/BRIEF.md
# Interrupt Aggregator with Edge and Pin-Change Detection

This block gathers every interrupt source of a small 8-bit controller core into one request line. Its sources are a core timer overflow, an external interrupt pin with selectable edge polarity, a group of port pins watched for any level change, and four peripheral events. Each source has a sticky flag and an enable bit. The peripheral sources sit behind an extra group enable. A global enable gates everything. The global enable is cleared when the CPU accepts an interrupt, and it is set again when the CPU returns from the handler.

The CPU reaches the registers through a byte-wide register port. Writes are strobed. Read data is combinational from the selected address. The external pin and the port pins pass through a synchronizer before any edge or change detection. Change detection compares the synchronized pins against a snapshot, and a read of the port address refreshes that snapshot. This lets the handler remove the cause of a change before it clears the flag. The block also presents a fixed handler entry address for the fetch logic.

Register addresses (on `reg_addr`):

| Address | Register |
|---|---|
| 0 | core control |
| 1 | peripheral enable |
| 2 | peripheral flag |
| 3 | per-pin change enable, bits NPINS-1:0 |
| 4 | edge select, bit 0 |
| 5 | synchronized port pins (read only) |
| 6, 7 | read as 0 |

Top module: `irq_hub`

## Requirements
- R1: After reset, the registers read as follows, and `irq_req` is 0:
  - core control 0x00
  - peripheral enable 0x00
  - peripheral flag 0x00
  - change enable 0x00
  - edge select 0x01
- R2: Core control (address 0) holds, from bit 7 down to bit 0:
  - global enable
  - peripheral-group enable
  - timer enable
  - external-pin enable
  - port-change enable
  - timer flag
  - external-pin flag
  - port-change flag

  A write to address 0 is read back unchanged.
- R3: The peripheral enable register (address 1) and the peripheral flag register (address 2) implement only bits 7, 6, 3 and 0. All other bits read 0. The events map onto the flag register as follows:
  - `periph_evt[3]` (EEPROM write done) sets bit 7
  - `periph_evt[2]` (conversion done) sets bit 6
  - `periph_evt[1]` (comparator change) sets bit 3
  - `periph_evt[0]` (16-bit timer overflow) sets bit 0
- R4: Every flag is set by its event whatever the state of its own enable, the group enable or the global enable.
- R5: A flag stays set until software writes 0 to it. If an event and a clearing write fall in the same cycle, the flag ends up set.
- R6: With edge select 1, a rising edge on `ext_pin` sets the external-pin flag and a falling edge does not. With edge select 0, the reverse holds.
- R7: The port-change flag sets when any synchronized port pin differs from its snapshot. Only pins whose change-enable bit is 1 count.
- R8: A read of address 5 returns the synchronized pins and loads them into the snapshot. Until then, a pending mismatch re-sets the port-change flag after a clearing write.
- R9: `irq_req` is 1 exactly when the global enable is 1 and at least one of these holds:
  - a core enable/flag pair is both set
  - the group enable is 1 and some peripheral enable/flag pair is both set
- R10: `irq_ack` clears the global enable. `irq_ret` sets it. If both come in the same cycle, `irq_ack` wins.
- R11: A pin level applied before a rising clock edge shows in a flag only after the third rising edge: two synchronizer stages plus the flag register.
- R12: `irq_vector` always presents handler address 0x0004.
- R13: A one-cycle `tmr_ovf_evt` pulse sets core bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_addr | input | 3 | register select |
| wr_en | input | 1 | write strobe |
| rd_en | input | 1 | read strobe (refreshes snapshot at address 5) |
| wr_data | input | 8 | write data |
| rd_data | output | 8 | read data of the selected register |
| ext_pin | input | 1 | external interrupt pin |
| port_pins | input | NPINS | port pins watched for change |
| tmr_ovf_evt | input | 1 | core timer overflow pulse |
| periph_evt | input | 4 | peripheral event pulses |
| irq_ack | input | 1 | CPU interrupt-accept strobe |
| irq_ret | input | 1 | CPU return-from-interrupt strobe |
| irq_req | output | 1 | interrupt request to the CPU |
| irq_vector | output | VEC_W | handler entry address |

## Verification
The bench builds the block with its defaults: six port pins and two synchronizer stages. This keeps the whole change-enable space small enough to sweep. Every one of the 64 masks is combined with a toggle on each of the six pins. In addition, all 256 core control patterns are crossed with a peripheral pair that is present or absent, so the whole request equation is covered. The default two-stage depth also fixes the flag latency at three edges, and the bench checks it cycle by cycle.

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NPINS       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W       = 13,
  parameter logic [VEC_W-1:0] VECTOR = 13'h0004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             ext_pin,
  input  logic [NPINS-1:0] port_pins,
  input  logic             tmr_ovf_evt,
  input  logic [3:0]       periph_evt,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector
);
  localparam logic [2:0] A_CORE = 3'd0, A_PEN = 3'd1, A_PFLG = 3'd2,
                         A_CHGEN = 3'd3, A_EDGE = 3'd4, A_PORT = 3'd5;
  localparam logic [7:0] PMASK = 8'hC9;
  localparam int PW = SYNC_STAGES * NPINS;

  logic [SYNC_STAGES-1:0] ext_pipe;
  logic [PW-1:0]          pin_pipe;
  logic                   ext_prev;
  logic [NPINS-1:0]       snap, chg_en;
  logic                   edge_sel;
  logic [7:0]             core_q, pen_q, pflag_q;
  logic [7:0]             core_d, pflag_d, pevt;

  wire             ext_s  = ext_pipe[SYNC_STAGES-1];
  wire [NPINS-1:0] pins_s = pin_pipe[PW-1 -: NPINS];
  wire ext_edge = edge_sel ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
  wire pin_chg  = |((pins_s ^ snap) & chg_en);
  wire wr_core  = wr_en && reg_addr == A_CORE;
  wire wr_pflg  = wr_en && reg_addr == A_PFLG;

  assign pevt = {periph_evt[3], periph_evt[2], 2'b00, periph_evt[1], 2'b00, periph_evt[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_pipe <= '0;
      pin_pipe <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_pipe <= {ext_pipe[SYNC_STAGES-2:0], ext_pin};
      pin_pipe <= {pin_pipe[PW-NPINS-1:0], port_pins};
      ext_prev <= ext_s;
    end

  always_comb begin
    core_d    = wr_core ? wr_data : core_q;
    core_d[2] = core_d[2] | tmr_ovf_evt;
    core_d[1] = core_d[1] | ext_edge;
    core_d[0] = core_d[0] | pin_chg;
    if (irq_ack)      core_d[7] = 1'b0;
    else if (irq_ret) core_d[7] = 1'b1;
    pflag_d = ((wr_pflg ? wr_data : pflag_q) | pevt) & PMASK;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      core_q   <= '0;
      pen_q    <= '0;
      pflag_q  <= '0;
      chg_en   <= '0;
      edge_sel <= 1'b1;
      snap     <= '0;
    end else begin
      core_q  <= core_d;
      pflag_q <= pflag_d;
      if (wr_en && reg_addr == A_PEN)   pen_q    <= wr_data & PMASK;
      if (wr_en && reg_addr == A_CHGEN) chg_en   <= wr_data[NPINS-1:0];
      if (wr_en && reg_addr == A_EDGE)  edge_sel <= wr_data[0];
      if (rd_en && reg_addr == A_PORT)  snap     <= pins_s;
    end

  always_comb begin
    rd_data = '0;
    case (reg_addr)
      A_CORE:  rd_data = core_q;
      A_PEN:   rd_data = pen_q;
      A_PFLG:  rd_data = pflag_q;
      A_CHGEN: rd_data[NPINS-1:0] = chg_en;
      A_EDGE:  rd_data[0] = edge_sel;
      A_PORT:  rd_data[NPINS-1:0] = pins_s;
      default: rd_data = '0;
    endcase
  end

  assign irq_req = core_q[7] & ((|(core_q[5:3] & core_q[2:0])) |
                                (core_q[6] & (|(pen_q & pflag_q))));
  assign irq_vector = VECTOR;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       wr_en,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       irq_req,
  input logic       tmr_ovf_evt,
  input logic       adc_evt,
  input logic [7:0] core_q,
  input logic [7:0] pflag_q
);
  // R10
  gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_ack |=> !core_q[7]);
  // R10
  gie_restore_chk: assert property (@(posedge clk) disable iff (!rst_n) (irq_ret && !irq_ack) |=> core_q[7]);
  // R9
  req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> core_q[7]);
  // R5
  tflag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_q[2]) |-> $past(wr_en && reg_addr == 3'd0));
  // R13
  tmr_evt_chk: assert property (@(posedge clk) disable iff (!rst_n) tmr_ovf_evt |=> core_q[2]);
  // R4
  adc_evt_chk: assert property (@(posedge clk) disable iff (!rst_n) adc_evt |=> pflag_q[6]);
endmodule

bind irq_hub irq_hub_chk chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
  .tmr_ovf_evt(tmr_ovf_evt), .adc_evt(periph_evt[2]),
  .core_q(core_q), .pflag_q(pflag_q)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic       clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       ext_pin = 0;
  logic [5:0] port_pins = 0;
  logic       tmr_ovf_evt = 0;
  logic [3:0] periph_evt = 0;
  logic       irq_ack = 0, irq_ret = 0, irq_req;
  logic [12:0] irq_vector;
  int checks = 0, fails = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  irq_hub uut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; rd_en = 1; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rd(0, v); chk("R1 core", v, 8'h00);
    rd(1, v); chk("R1 pen", v, 8'h00);
    rd(2, v); chk("R1 pflag", v, 8'h00);
    rd(3, v); chk("R1 chgen", v, 8'h00);
    rd(4, v); chk("R1 edge", v, 8'h01);
    chk("R1 irq_req", irq_req, 0);
    chk("R12 vector", irq_vector, 13'h0004);

    wr(0, 8'h5A); rd(0, v); chk("R2 readback", v, 8'h5A);
    wr(0, 8'h00);
    wr(1, 8'hFF); rd(1, v); chk("R3 pen bits", v, 8'hC9);
    wr(2, 8'hFF); rd(2, v); chk("R3 pflag bits", v, 8'hC9);
    wr(1, 8'h00); wr(2, 8'h00);

    for (int k = 0; k < 4; k++) begin
      @(negedge clk); periph_evt[k] = 1;
      @(negedge clk); periph_evt = 0;
      rd(2, v);
      chk("R3 R4 event map", v, k == 3 ? 8'h80 : k == 2 ? 8'h40 : k == 1 ? 8'h08 : 8'h01);
      wr(2, 8'h00);
    end
    @(negedge clk); tmr_ovf_evt = 1;
    @(negedge clk); tmr_ovf_evt = 0;
    rd(0, v); chk("R13 R4 timer flag", v, 8'h04);
    tick(20); rd(0, v); chk("R5 flag persists", v, 8'h04);
    wr(0, 8'h00); rd(0, v); chk("R5 cleared by write", v, 8'h00);
    @(negedge clk); reg_addr = 2; wr_data = 0; wr_en = 1; periph_evt[0] = 1;
    @(negedge clk); wr_en = 0; periph_evt = 0;
    rd(2, v); chk("R5 event beats clear", v, 8'h01);
    wr(2, 8'h00);

    // rising edge, latency
    @(negedge clk); reg_addr = 0; ext_pin = 1;
    @(negedge clk); chk("R11 edge1", rd_data[1], 0);
    @(negedge clk); chk("R11 edge2", rd_data[1], 0);
    @(negedge clk); chk("R11 edge3", rd_data[1], 1);
    wr(0, 8'h00);
    @(negedge clk); ext_pin = 0; tick(4);
    rd(0, v); chk("R6 falling ignored sel1", v[1], 0);
    wr(4, 8'h00);
    @(negedge clk); ext_pin = 1; tick(4);
    rd(0, v); chk("R6 rising ignored sel0", v[1], 0);
    @(negedge clk); ext_pin = 0; tick(4);
    rd(0, v); chk("R6 falling sets sel0", v[1], 1);
    wr(0, 8'h00); wr(4, 8'h01);

    for (int m = 0; m < 64; m++)
      for (int p = 0; p < 6; p++) begin
        wr(3, 8'(m)); rd(5, v); wr(0, 8'h00);
        @(negedge clk); port_pins[p] = ~port_pins[p]; tick(4);
        rd(0, v); chk("R7 mask sweep", v[0], m[p]);
        rd(5, v); chk("R8 port read", v, {2'b00, port_pins});
        wr(0, 8'h00);
      end

    wr(3, 8'h3F); rd(5, v); wr(0, 8'h00);
    @(negedge clk); port_pins[0] = ~port_pins[0]; tick(4);
    wr(0, 8'h00); rd(0, v); chk("R8 mismatch resets flag", v[0], 1);
    rd(5, v); wr(0, 8'h00); tick(3);
    rd(0, v); chk("R8 cleared after snapshot", v[0], 0);
    wr(3, 8'h00);

    for (int c = 0; c < 256; c++)
      for (int pp = 0; pp < 2; pp++) begin
        logic [7:0] cv;
        logic e;
        cv = 8'(c);
        wr(1, pp ? 8'h40 : 8'h08);
        wr(2, 8'h48 & (pp ? 8'h40 : 8'h00));
        wr(0, cv);
        e = cv[7] & ((cv[5] & cv[2]) | (cv[4] & cv[1]) | (cv[3] & cv[0]) | (cv[6] & (pp == 1)));
        chk("R9 request sweep", irq_req, e);
      end
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'h00);

    wr(0, 8'hA4); chk("R9 request on", irq_req, 1);
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    rd(0, v); chk("R10 ack clears gie", v, 8'h24);
    chk("R10 request off", irq_req, 0);
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
    rd(0, v); chk("R10 ret sets gie", v, 8'hA4);
    @(negedge clk); irq_ack = 1; irq_ret = 1;
    @(negedge clk); irq_ack = 0; irq_ret = 0;
    rd(0, v); chk("R10 ack wins", v[7], 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule